// File: doc/BRIEF.md
# Bit-Split Multi-Pattern Rule Module

This block searches a byte stream for every occurrence of up to sixteen patterns at a rate of one byte per clock. It does not hold a single automaton with 256 branches per state. Instead, each incoming byte is cut into four 2-bit symbols, and each symbol drives its own small tile automaton. Each tile state has only four successors.

Every tile stores a programmable table. Each row of that table holds the four successor states and a 16-bit partial match vector. A pattern is reported only when all four tiles flag it at once, so the reported vector is the bitwise AND of the four partial vectors. The tables are built offline and loaded through a row-write configuration port. Because the tables come from the full multi-pattern automaton, the module reports exactly the matches that automaton would report. The result is registered and accompanied by a one-cycle valid strobe.

Each tile behaves as a state machine, with state 0 as its start state. It has three transitions:
- **step**: on an accepted byte, the tile moves to the successor chosen by its symbol.
- **flush**: the tile returns to state 0.
- **hold**: with no byte and no flush, the tile keeps its state.

The output stage has two conditions. It is **idle** (valid low) when no byte was accepted in the previous cycle. It is **report** (valid high) in the cycle after an accepted byte. Several modules can sit side by side, with their vectors concatenated to cover a larger rule set.

Top module: `bsm_rule_module`

## Requirements
- R1: Tile 0 receives byte bits 7:6, tile 1 bits 5:4, tile 2 bits 3:2 and tile 3 bits 1:0. For example, 0x68 gives symbols 1, 2, 2, 0.
- R2: A write with `cfg_we` high stores `cfg_row` into row `cfg_state` of the tile selected by `cfg_tile`. The row is laid out as `{next[3], next[2], next[1], next[0], pmv}`, where `pmv` occupies bits NUM_PAT-1:0 and `next[v]` is the STATE_W-bit successor for symbol v. The write affects every byte accepted after the write edge.
- R3: On an accepted byte (`in_valid` high, `flush` low), every tile moves to the successor its symbol selects. The match vector is the AND of the partial match vectors stored in the four new states.
- R4: `out_valid` is high exactly in the cycle after an accepted byte. `out_match` carries that byte's result in the same cycle.
- R5: When no byte is accepted and there is no flush, `out_match` keeps its value and `out_valid` is low.
- R6: When `flush` is high, all tiles return to state 0 and any byte presented in that cycle is discarded. In the next cycle `out_match` is zero and `out_valid` is low. A pattern can never span a flush.
- R7: After reset, all tiles are in state 0, all table rows are zero, `out_match` is zero and `out_valid` is low.
- R8: When loaded with tables derived from a pattern group, the module reports every occurrence of every pattern ending on each byte. This includes several patterns ending on the same byte, such as "she" and "he".
- R9: With the group {hers, his, she, he} on vector bits 0 to 3, the stream h, x, h, e gives 0, 0, 0 and 0x0008.
- R10: Any byte value from 0x00 to 0xFF can appear in a pattern or in the stream, including repeated bytes that produce self-overlapping matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Payload byte strobe |
| in_byte | input | 8 | Payload byte |
| flush | input | 1 | Return all tiles to the start state; discards the byte in that cycle |
| cfg_we | input | 1 | Table row write enable |
| cfg_tile | input | 2 | Tile selected for the write |
| cfg_state | input | STATE_W | Row (tile state) written |
| cfg_row | input | 4*STATE_W+NUM_PAT | Row contents: four successors and a partial match vector |
| out_valid | output | 1 | Result strobe, one cycle after an accepted byte |
| out_match | output | NUM_PAT | Full match vector, held between bytes |

## Verification
The checker watches four properties on every cycle:
- the one-cycle relation between accepted bytes and `out_valid`;
- the clearing of the vector and of every tile state after a flush;
- the holding of the vector while the stream is idle;
- that each reported bit is also set in every tile's partial vector.

Only the bench's scenarios can show the remaining behaviour: the bit-pair order of the slicing, the row layout of the configuration port, and that four independent 2-bit automata together find exactly the matches that a plain suffix search finds. The bench checks this last point on long mixed streams with overlapping and self-overlapping patterns.

// File: rtl/bsm_pkg.sv
`timescale 1ns/1ps
package bsm_pkg;
    localparam int BYTE_W = 8;
    localparam int SYM_W  = 2;
    localparam int TILES  = BYTE_W / SYM_W;
    localparam int SYMS   = 1 << SYM_W;
    localparam int TSEL_W = $clog2(TILES);

    typedef logic [SYM_W-1:0] sym_t;
endpackage

// File: rtl/bsm_slicer.sv
`timescale 1ns/1ps
// Cuts one byte into per-tile symbols, highest bit pair to tile 0.
module bsm_slicer
    import bsm_pkg::*;
(
    input  logic [BYTE_W-1:0]           byte_in,
    output logic [TILES-1:0][SYM_W-1:0] sym_out
);
    for (genvar t = 0; t < TILES; t++) begin : g_slice
        assign sym_out[t] = byte_in[BYTE_W-1-SYM_W*t -: SYM_W];
    end
endmodule

// File: rtl/bsm_tile.sv
`timescale 1ns/1ps
// One bit-split automaton: programmable transition table plus state register.
module bsm_tile
    import bsm_pkg::*;
#(
    parameter  int NUM_PAT = 16,
    parameter  int NSTATES = 32,
    localparam int STATE_W = $clog2(NSTATES),
    localparam int ROW_W   = SYMS * STATE_W + NUM_PAT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step,
    input  logic               clear,
    input  sym_t               sym,
    input  logic               wr_en,
    input  logic [STATE_W-1:0] wr_addr,
    input  logic [ROW_W-1:0]   wr_row,
    output logic [STATE_W-1:0] state_q,
    output logic [NUM_PAT-1:0] pmv
);
    logic [ROW_W-1:0]   rows [NSTATES];
    logic [STATE_W-1:0] nxt;

    // successor lookup for the presented symbol
    always_comb begin
        nxt = rows[state_q][NUM_PAT + int'(sym) * STATE_W +: STATE_W];
        pmv = rows[nxt][NUM_PAT-1:0];
    end

    // state register: flush beats step, otherwise hold
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else if (clear) begin
            state_q <= '0;
        end else if (step) begin
            state_q <= nxt;
        end
    end

    // transition table
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSTATES; i++) begin
                rows[i] <= '0;
            end
        end else if (wr_en) begin
            rows[wr_addr] <= wr_row;
        end
    end
endmodule

// File: rtl/bsm_combine.sv
`timescale 1ns/1ps
// Intersects the partial vectors and latches the result.
module bsm_combine
    import bsm_pkg::*;
#(
    parameter int NUM_PAT = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            step,
    input  logic                            clear,
    input  logic [TILES-1:0][NUM_PAT-1:0]   pmv_all,
    output logic                            out_valid,
    output logic [NUM_PAT-1:0]              out_match
);
    logic [NUM_PAT-1:0] agree;

    always_comb begin
        agree = '1;
        for (int t = 0; t < TILES; t++) begin
            agree &= pmv_all[t];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_match <= '0;
        end else if (clear) begin
            out_valid <= 1'b0;
            out_match <= '0;
        end else if (step) begin
            out_valid <= 1'b1;
            out_match <= agree;
        end else begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/bsm_rule_module.sv
`timescale 1ns/1ps
// Rule module: slices each byte across four bit-split tiles and ANDs their votes.
module bsm_rule_module
    import bsm_pkg::*;
#(
    parameter  int NUM_PAT = 16,
    parameter  int NSTATES = 32,
    localparam int STATE_W = $clog2(NSTATES),
    localparam int ROW_W   = SYMS * STATE_W + NUM_PAT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [BYTE_W-1:0]  in_byte,
    input  logic               flush,
    input  logic               cfg_we,
    input  logic [TSEL_W-1:0]  cfg_tile,
    input  logic [STATE_W-1:0] cfg_state,
    input  logic [ROW_W-1:0]   cfg_row,
    output logic               out_valid,
    output logic [NUM_PAT-1:0] out_match
);
    logic                            step;
    logic [TILES-1:0][SYM_W-1:0]     sym_vec;
    logic [TILES-1:0][STATE_W-1:0]   tile_state;
    logic [TILES-1:0][NUM_PAT-1:0]   tile_pmv;

    assign step = in_valid & ~flush;

    bsm_slicer u_slicer (
        .byte_in (in_byte),
        .sym_out (sym_vec)
    );

    for (genvar t = 0; t < TILES; t++) begin : g_tile
        bsm_tile #(
            .NUM_PAT (NUM_PAT),
            .NSTATES (NSTATES)
        ) u_tile (
            .clk     (clk),
            .rst_n   (rst_n),
            .step    (step),
            .clear   (flush),
            .sym     (sym_vec[t]),
            .wr_en   (cfg_we && (cfg_tile == TSEL_W'(t))),
            .wr_addr (cfg_state),
            .wr_row  (cfg_row),
            .state_q (tile_state[t]),
            .pmv     (tile_pmv[t])
        );
    end

    bsm_combine #(
        .NUM_PAT (NUM_PAT)
    ) u_combine (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .clear     (flush),
        .pmv_all   (tile_pmv),
        .out_valid (out_valid),
        .out_match (out_match)
    );
endmodule

// File: rtl/bsm_rule_module_chk.sv
`timescale 1ns/1ps
module bsm_rule_module_chk
    import bsm_pkg::*;
#(
    parameter int NUM_PAT = 16,
    parameter int STATE_W = 5
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          in_valid,
    input logic                          flush,
    input logic                          out_valid,
    input logic [NUM_PAT-1:0]            out_match,
    input logic [TILES-1:0][STATE_W-1:0] tile_state,
    input logic [TILES-1:0][NUM_PAT-1:0] tile_pmv
);
    // R4
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !flush) |=> out_valid);

    // R4
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && !flush) |=> !out_valid);

    // R6
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (out_match == '0 && tile_state == '0));

    // R5
    hold_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !flush) |=> $stable(out_match));

    for (genvar t = 0; t < TILES; t++) begin : g_sub
        // R3
        pmv_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !flush) |=> ((out_match & ~$past(tile_pmv[t])) == '0));
    end
endmodule

bind bsm_rule_module bsm_rule_module_chk #(
    .NUM_PAT (NUM_PAT),
    .STATE_W (STATE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .flush      (flush),
    .out_valid  (out_valid),
    .out_match  (out_match),
    .tile_state (tile_state),
    .tile_pmv   (tile_pmv)
);

// File: tb/tb_bsm_rule_module.sv
`timescale 1ns/1ps
module tb_bsm_rule_module;
    localparam int NP = 16;
    localparam int NS = 32;
    localparam int SW = 5;
    localparam int RW = 4 * SW + NP;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_byte = '0;
    logic          flush = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_tile = '0;
    logic [SW-1:0] cfg_state = '0;
    logic [RW-1:0] cfg_row = '0;
    logic          out_valid;
    logic [NP-1:0] out_match;

    always #10 clk = ~clk;

    bsm_rule_module #(.NUM_PAT(NP), .NSTATES(NS)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .flush(flush), .cfg_we(cfg_we), .cfg_tile(cfg_tile),
        .cfg_state(cfg_state), .cfg_row(cfg_row),
        .out_valid(out_valid), .out_match(out_match));

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // pattern group and derived automata (offline construction in the bench)
    int          pat_b   [16][8];
    int          pat_len [16];
    int          npat;
    int          node_s  [64][8];
    int          node_len[64];
    int          nnodes;
    int          dlt     [64][256];
    logic [15:0] nout    [64];
    int          tmp     [9];
    int          tnext   [4][32][4];
    logic [15:0] tpmv    [4][32];
    int          tcnt    [4];
    logic [63:0] tset    [32];

    // reference window: win[0] is newest byte since last flush
    int win [8];
    int seen;

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int find_tmp(int off, int k);
        for (int n = 0; n < nnodes; n++) begin
            if (node_len[n] == k) begin
                bit ok = 1;
                for (int i = 0; i < k; i++)
                    if (node_s[n][i] != tmp[off + i]) ok = 0;
                if (ok) return n;
            end
        end
        return -1;
    endfunction

    task automatic build_tables();
        nnodes = 1;
        node_len[0] = 0;
        for (int p = 0; p < npat; p++)
            for (int k = 1; k <= pat_len[p]; k++) begin
                for (int i = 0; i < k; i++) tmp[i] = pat_b[p][i];
                if (find_tmp(0, k) < 0) begin
                    for (int i = 0; i < k; i++) node_s[nnodes][i] = tmp[i];
                    node_len[nnodes] = k;
                    nnodes++;
                end
            end
        for (int n = 0; n < nnodes; n++) begin
            nout[n] = '0;
            for (int p = 0; p < npat; p++) begin
                int L = node_len[n];
                int m = pat_len[p];
                if (m <= L) begin
                    bit ok = 1;
                    for (int i = 0; i < m; i++)
                        if (node_s[n][L - m + i] != pat_b[p][i]) ok = 0;
                    if (ok) nout[n][p] = 1'b1;
                end
            end
        end
        for (int n = 0; n < nnodes; n++)
            for (int c = 0; c < 256; c++) begin
                int L = node_len[n];
                int r = -1;
                for (int i = 0; i < L; i++) tmp[i] = node_s[n][i];
                tmp[L] = c;
                for (int k = L + 1; k >= 0; k--)
                    if (r < 0) r = find_tmp(L + 1 - k, k);
                dlt[n][c] = r;
            end
        for (int t = 0; t < 4; t++) begin
            int cnt = 1;
            int i = 0;
            tset[0] = 64'd1;
            while (i < cnt) begin
                tpmv[t][i] = '0;
                for (int s = 0; s < nnodes; s++)
                    if (tset[i][s]) tpmv[t][i] |= nout[s];
                for (int v = 0; v < 4; v++) begin
                    logic [63:0] u = '0;
                    int j = -1;
                    for (int s = 0; s < nnodes; s++)
                        if (tset[i][s])
                            for (int c = 0; c < 256; c++)
                                if (((c >> (6 - 2 * t)) & 3) == v) u[dlt[s][c]] = 1'b1;
                    for (int q = 0; q < cnt; q++)
                        if (tset[q] == u) j = q;
                    if (j < 0) begin
                        if (cnt < NS) begin
                            tset[cnt] = u;
                            j = cnt;
                            cnt++;
                        end else begin
                            chk("R8", "tile state count within table", cnt + 1, NS);
                            j = 0;
                        end
                    end
                    tnext[t][i][v] = j;
                end
                i++;
            end
            tcnt[t] = cnt;
        end
    endtask

    task automatic cfg_write(int t, int s, logic [RW-1:0] row);
        cfg_we = 1'b1;
        cfg_tile = 2'(t);
        cfg_state = SW'(s);
        cfg_row = row;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_tables();
        for (int t = 0; t < 4; t++)
            for (int s = 0; s < NS; s++) begin
                logic [RW-1:0] row = '0;
                if (s < tcnt[t]) begin
                    row[NP-1:0] = tpmv[t][s];
                    for (int v = 0; v < 4; v++)
                        row[NP + v * SW +: SW] = SW'(tnext[t][s][v]);
                end
                cfg_write(t, s, row);
            end
    endtask

    function automatic int ref_vec();
        int r = 0;
        for (int p = 0; p < npat; p++) begin
            int m = pat_len[p];
            if (m <= seen) begin
                bit ok = 1;
                for (int i = 0; i < m; i++)
                    if (pat_b[p][m - 1 - i] != win[i]) ok = 0;
                if (ok) r |= (1 << p);
            end
        end
        return r;
    endfunction

    // drive one byte and check the result one cycle later
    task automatic push(int b, string req);
        int e;
        for (int i = 7; i > 0; i--) win[i] = win[i - 1];
        win[0] = b;
        seen++;
        e = ref_vec();
        in_valid = 1'b1;
        in_byte = 8'(b);
        @(negedge clk);
        chk(req, "out_valid", int'(out_valid), 1);
        chk(req, "out_match", int'(out_match), e);
    endtask

    task automatic idle();
        in_valid = 1'b0;
    endtask

    task automatic do_flush(int b);
        in_valid = 1'b1;
        in_byte = 8'(b);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        in_valid = 1'b0;
        seen = 0;
        chk("R6", "out_valid after flush", int'(out_valid), 0);
        chk("R6", "out_match after flush", int'(out_match), 0);
    endtask

    task automatic set_pat(int p, int len, int b0, int b1, int b2, int b3);
        pat_len[p] = len;
        pat_b[p][0] = b0; pat_b[p][1] = b1; pat_b[p][2] = b2; pat_b[p][3] = b3;
    endtask

    task automatic t_reset();
        chk("R7", "out_valid in reset", int'(out_valid), 0);
        chk("R7", "out_match in reset", int'(out_match), 0);
        rst_n = 1'b1;
        @(negedge clk);
        npat = 0;
        seen = 0;
        push(8'hFF, "R7");
        push(8'h00, "R7");
        idle();
        @(negedge clk);
    endtask

    // each tile in turn reports its symbol as a one-hot; others vote all-ones
    task automatic t_slice();
        int bytes [2] = '{8'h68, 8'hB1};
        for (int tgt = 0; tgt < 4; tgt++) begin
            for (int t = 0; t < 4; t++)
                for (int s = 0; s < 4; s++) begin
                    logic [RW-1:0] row = '0;
                    row[NP-1:0] = (t == tgt) ? NP'(1 << s) : {NP{1'b1}};
                    for (int v = 0; v < 4; v++) row[NP + v * SW +: SW] = SW'(v);
                    cfg_write(t, s, row);
                end
            foreach (bytes[k]) begin
                int sym = (bytes[k] >> (6 - 2 * tgt)) & 3;
                in_valid = 1'b1;
                in_byte = 8'(bytes[k]);
                @(negedge clk);
                chk("R1", "symbol one-hot from tile", int'(out_match), 1 << sym);
                chk("R2", "valid with loaded row", int'(out_valid), 1);
            end
            idle();
        end
    endtask

    task automatic t_example();
        do_flush(0);
        push("h", "R9"); chk("R9", "h", int'(out_match), 0);
        push("x", "R9"); chk("R9", "x", int'(out_match), 0);
        push("h", "R9"); chk("R9", "h", int'(out_match), 0);
        push("e", "R9"); chk("R9", "e gives he", int'(out_match), 16'h0008);
        idle();
    endtask

    task automatic t_overlap();
        do_flush(0);
        push("u", "R8");
        push("s", "R8");
        push("h", "R8");
        push("e", "R8"); chk("R8", "she and he together", int'(out_match), 16'h000C);
        push("r", "R8");
        push("s", "R8"); chk("R8", "hers", int'(out_match), 16'h0001);
        idle();
    endtask

    task automatic t_hold();
        do_flush(0);
        push("h", "R5");
        push("e", "R5");
        idle();
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R5", "valid low while idle", int'(out_valid), 0);
            chk("R5", "vector held while idle", int'(out_match), 16'h0008);
        end
    endtask

    task automatic t_flush();
        do_flush(0);
        push("h", "R6");
        do_flush("e");
        push("e", "R6"); chk("R6", "no match across flush", int'(out_match), 0);
        push("h", "R6");
        push("e", "R6"); chk("R6", "match after flush", int'(out_match), 16'h0008);
        idle();
    endtask

    task automatic t_random(int nbytes, int alpha[6], string req);
        do_flush(0);
        for (int k = 0; k < nbytes; k++) begin
            int r = $urandom % 100;
            if (r == 0) begin
                do_flush($urandom % 256);
            end else if (r < 20) begin
                int p = $urandom % npat;
                for (int i = 0; i < pat_len[p]; i++) push(pat_b[p][i], req);
            end else if (r < 90) begin
                push(alpha[$urandom % 6], req);
            end else begin
                push($urandom % 256, req);
            end
        end
        idle();
        @(negedge clk);
    endtask

    task automatic t_bytes_edge();
        do_flush(0);
        push(8'hFF, "R10"); chk("R10", "FF", int'(out_match), 16'h0004);
        push(8'hFF, "R10");
        push(8'hFF, "R10"); chk("R10", "FF FF FF", int'(out_match), 16'h0006);
        push(8'hFF, "R10"); chk("R10", "FF x4 overlap", int'(out_match), 16'h0006);
        push(8'h00, "R10");
        push(8'h00, "R10"); chk("R10", "00 00", int'(out_match), 16'h0008);
        push(8'hFF, "R10"); chk("R10", "00 FF", int'(out_match), 16'h0005);
        idle();
    endtask

    initial begin
        int alpha1 [6] = '{"h", "e", "r", "s", "i", "x"};
        int alpha2 [6] = '{8'h00, 8'hFF, 8'h80, 8'h7F, 8'h61, 8'h62};
        repeat (3) @(negedge clk);
        t_reset();
        t_slice();

        // group 1: bit0 hers, bit1 his, bit2 she, bit3 he
        npat = 4;
        set_pat(0, 4, "h", "e", "r", "s");
        set_pat(1, 3, "h", "i", "s", 0);
        set_pat(2, 3, "s", "h", "e", 0);
        set_pat(3, 2, "h", "e", 0, 0);
        build_tables();
        load_tables();
        t_example();
        t_overlap();
        t_hold();
        t_flush();
        t_random(2000, alpha1, "R8");

        // group 2: wide byte values and self-overlap
        npat = 7;
        set_pat(0, 2, 8'h00, 8'hFF, 0, 0);
        set_pat(1, 3, 8'hFF, 8'hFF, 8'hFF, 0);
        set_pat(2, 1, 8'hFF, 0, 0, 0);
        set_pat(3, 2, 8'h00, 8'h00, 0, 0);
        set_pat(4, 2, 8'h80, 8'h7F, 0, 0);
        set_pat(5, 2, 8'h61, 8'h61, 0, 0);
        set_pat(6, 3, 8'h61, 8'h61, 8'h61, 0);
        build_tables();
        load_tables();
        t_bytes_edge();
        t_random(2000, alpha2, "R10");

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule